// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Controller

This block is the per-processor controller for a small direct-mapped write-back cache that sits on a shared, serialised bus. Each cache line is always in one of three coherence states: invalid, shared (clean, other caches may also hold it) or exclusive (dirty and the only valid copy). One state machine handles both the processor's requests and the transactions of other bus agents that this cache snoops. One bus command runs at a time. This serialisation gives every cache the same order of writes to any one address.

The processor request port is a valid/ready stream. The requester raises `cpu_req_valid` and holds the write flag, address and write data stable until `cpu_req_ready` is high. The request is accepted and completed in the same cycle as `cpu_req_ready`, and read data is valid on `cpu_rdata` only in that cycle. Hits complete in the cycle they are presented. Misses stall the requester while the controller arbitrates for the bus, writes back a dirty victim if there is one, and then runs a read-miss or write-miss command. Blocks are one data word.

The bus side is plain control. The controller raises `bus_req` and waits for `bus_gnt`. It then issues one command with a single-cycle `bus_cmd_valid` and waits for a single-cycle `bus_done`. On a read-miss or write-miss, `bus_done` carries the block on `bus_rdata`. Commands issued by other agents arrive on the snoop port. The arbiter must keep `bus_gnt` high for as long as `bus_req` stays high. It must never present a snoop while this cache owns the bus.

Top module: `snoop_wi_cache`

## Requirements
- R1: After reset every line is invalid. `bus_req`, `bus_cmd_valid` and `snp_supply` are low, and a snooped read-miss gets no data supply.
- R2: A processor read to a line that is not valid with a matching tag raises `bus_req`. Once granted, it issues one read-miss command (`bus_cmd` code 1) carrying the request address. It completes in the `bus_done` cycle with `cpu_rdata` = `bus_rdata`, and it leaves the line shared.
- R3: A processor read that hits a shared or exclusive line completes in the same cycle with the line's data and issues no bus command.
- R4: A processor write to a shared or invalid line always issues a write-miss command (`bus_cmd` code 2) and completes on `bus_done`. The line becomes exclusive and holds the written word.
- R5: Reads and writes to an exclusive line complete in the cycle they are presented, with no bus command, and the line stays exclusive.
- R6: A snooped write-miss (`snp_cmd` code 2) whose address matches a valid line makes that line invalid, so the next processor read of that address misses.
- R7: A snooped read-miss (`snp_cmd` code 1) that hits an exclusive line raises `snp_supply` in the same cycle, with the line's word on `snp_data`. The line drops to shared, so a later processor write to it issues a write-miss.
- R8: A snooped read-miss that hits a shared line leaves `snp_supply` low and leaves the line shared.
- R9: A miss whose victim line is exclusive with a different tag first issues a write-back command (`bus_cmd` code 3) with the victim's address and word, and only then issues the miss command. A shared or invalid victim is dropped with no write-back.
- R10: In any cycle with `snp_valid` high, `cpu_req_ready` is low. The snoop is handled first and the processor request is served afterwards.
- R11: `bus_cmd_valid` is high only while `bus_gnt` is high, never in two consecutive cycles, and never before the previous command's `bus_done`.
- R12: A snoop whose tag differs from the line at its index has no effect on that line.
- R13: A missing request keeps `cpu_req_ready` low until its miss command's `bus_done`. `bus_req` stays high from the miss until that completion and falls only after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted and completed this cycle |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address of the request |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid when a read completes |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus granted to this controller |
| bus_cmd_valid | output | 1 | One-cycle command issue strobe |
| bus_cmd | output | 2 | 1 read-miss, 2 write-miss, 3 write-back |
| bus_addr | output | ADDR_W | Command address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_done | input | 1 | Current command finished |
| bus_rdata | input | DATA_W | Block data returned with `bus_done` |
| snp_valid | input | 1 | Another agent's command is on the bus |
| snp_cmd | input | 2 | Snooped command code (same encoding as `bus_cmd`) |
| snp_addr | input | ADDR_W | Snooped address |
| snp_supply | output | 1 | This cache supplies the block and memory must abort |
| snp_data | output | DATA_W | Supplied block data |

## Verification
A wrong coherence state in a line never shows up on its own. It shows up at the next access to that address. A stale exclusive or shared line turns a miss into a zero-wait hit that returns old data, and a line that was dropped too soon turns a hit into an extra read-miss. A stale exclusive line also answers a snoop with a supply it should not give, or skips a write-miss that should have appeared. A write-back that is lost or doubled shows up later as the wrong word when the victim address is refilled from memory. The bench therefore follows each snoop and eviction with processor accesses that expose the state within a few cycles, and it logs the exact sequence of bus commands.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_EXC = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE   = 2'd0,
    BC_RDMISS = 2'd1,
    BC_WRMISS = 2'd2,
    BC_WBACK  = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    F_IDLE  = 2'd0,
    F_ARB   = 2'd1,
    F_WBACK = 2'd2,
    F_MISS  = 2'd3
  } ctl_st_e;

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  cpu_idx,
  output line_st_e          cpu_st,
  output logic [TAG_W-1:0]  cpu_tag,
  output logic [DATA_W-1:0] cpu_data,
  input  logic [IDX_W-1:0]  snp_idx,
  output line_st_e          snp_st,
  output logic [TAG_W-1:0]  snp_tag,
  output logic [DATA_W-1:0] snp_data,
  input  logic              snp_upd_en,
  input  line_st_e          snp_upd_st,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  line_st_e          fill_st
);
  localparam int LINES = 1 << IDX_W;

  line_st_e          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  // coherence state: snoop updates win over local fills on the same line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LN_INV;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (snp_upd_en && snp_idx == IDX_W'(i))
          st_q[i] <= snp_upd_st;
        else if (fill_en && fill_idx == IDX_W'(i))
          st_q[i] <= fill_st;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else if (fill_en) begin
      tag_q[fill_idx]  <= fill_tag;
      data_q[fill_idx] <= fill_data;
    end
  end

  assign cpu_st   = st_q[cpu_idx];
  assign cpu_tag  = tag_q[cpu_idx];
  assign cpu_data = data_q[cpu_idx];
  assign snp_st   = st_q[snp_idx];
  assign snp_tag  = tag_q[snp_idx];
  assign snp_data = data_q[snp_idx];

  // R6/R7: a snoop update never raises a line to exclusive
  assert_snoop_no_promote_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_upd_en |-> snp_upd_st != LN_EXC);

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int TAG_W  = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  line_st_e          line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              supply,
  output logic [DATA_W-1:0] supply_data,
  output logic              upd_en,
  output line_st_e          upd_st
);
  logic match;

  assign match = snp_valid && (line_st != LN_INV) && (line_tag == snp_tag);

  always_comb begin
    supply      = 1'b0;
    supply_data = '0;
    upd_en      = 1'b0;
    upd_st      = line_st;
    if (match) begin
      if (snp_cmd == BC_WRMISS) begin
        upd_en = 1'b1;
        upd_st = LN_INV;
      end else if (snp_cmd == BC_RDMISS && line_st == LN_EXC) begin
        supply      = 1'b1;
        supply_data = line_data;
        upd_en      = 1'b1;
        upd_st      = LN_SHR;
      end
    end
  end

  // R7/R8: supplying data needs an exclusive line hit by a read-miss
  assert_supply_needs_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    supply |-> (snp_valid && snp_cmd == BC_RDMISS && line_st == LN_EXC));

  // R12: a tag mismatch never changes the line
  assert_mismatch_untouched_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && line_tag != snp_tag) |-> !upd_en);

endmodule

// File: rtl/coh_ctrl_fsm.sv
module coh_ctrl_fsm
  import coh_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 9,
  parameter int DATA_W = 32,
  localparam int ADDR_W = IDX_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [IDX_W-1:0]  cpu_idx,
  input  logic [TAG_W-1:0]  cpu_tag,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_req_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  input  line_st_e          line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  input  logic              snp_valid,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_cmd_valid,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_done,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              fill_en,
  output logic [TAG_W-1:0]  fill_tag,
  output logic [DATA_W-1:0] fill_data,
  output line_st_e          fill_st
);
  ctl_st_e fsm_q, fsm_d;
  logic    hit;

  assign hit     = (line_st != LN_INV) && (line_tag == cpu_tag);
  assign bus_req = (fsm_q != F_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fsm_q <= F_IDLE;
    else        fsm_q <= fsm_d;
  end

  always_comb begin
    fsm_d         = fsm_q;
    cpu_req_ready = 1'b0;
    cpu_rdata     = line_data;
    bus_cmd_valid = 1'b0;
    bus_cmd       = BC_NONE;
    bus_addr      = '0;
    bus_wdata     = '0;
    fill_en       = 1'b0;
    fill_tag      = cpu_tag;
    fill_data     = cpu_wdata;
    fill_st       = LN_EXC;
    case (fsm_q)
      F_IDLE: begin
        if (cpu_req_valid && !snp_valid) begin
          if (!cpu_req_write && hit) begin
            cpu_req_ready = 1'b1;
          end else if (cpu_req_write && hit && line_st == LN_EXC) begin
            cpu_req_ready = 1'b1;
            fill_en       = 1'b1;
          end else begin
            fsm_d = F_ARB;
          end
        end
      end
      F_ARB: begin
        // the victim is examined at grant time, after any snoop has acted
        if (bus_gnt && !snp_valid) begin
          bus_cmd_valid = 1'b1;
          if (line_st == LN_EXC && line_tag != cpu_tag) begin
            bus_cmd   = BC_WBACK;
            bus_addr  = {line_tag, cpu_idx};
            bus_wdata = line_data;
            fsm_d     = F_WBACK;
          end else begin
            bus_cmd   = cpu_req_write ? BC_WRMISS : BC_RDMISS;
            bus_addr  = {cpu_tag, cpu_idx};
            bus_wdata = cpu_wdata;
            fsm_d     = F_MISS;
          end
        end
      end
      F_WBACK: begin
        if (bus_done) begin
          fill_en   = 1'b1;
          fill_tag  = line_tag;
          fill_data = line_data;
          fill_st   = LN_INV;
          fsm_d     = F_ARB;
        end
      end
      F_MISS: begin
        if (bus_done) begin
          fill_en       = 1'b1;
          fill_data     = cpu_req_write ? cpu_wdata : bus_rdata;
          fill_st       = cpu_req_write ? LN_EXC : LN_SHR;
          cpu_req_ready = 1'b1;
          cpu_rdata     = bus_rdata;
          fsm_d         = F_IDLE;
        end
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  assert_issue_granted_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_valid |-> bus_gnt);

  assert_single_issue_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_valid |=> !bus_cmd_valid);

  assert_snoop_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_req_ready);

  assert_hold_bus_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> $past(cpu_req_ready));

  assert_wback_then_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_valid && bus_cmd == BC_WBACK) |=> !cpu_req_ready);

endmodule

// File: rtl/snoop_wi_cache.sv
module snoop_wi_cache
  import coh_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_cmd_valid,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_done,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  cpu_idx, snp_idx;
  logic [TAG_W-1:0]  cpu_tag, snp_tag;
  line_st_e          c_st, s_st, upd_st, fill_st;
  logic [TAG_W-1:0]  c_tag, s_tag, fill_tag;
  logic [DATA_W-1:0] c_data, s_data, fill_data;
  logic              upd_en, fill_en;

  assign cpu_idx = cpu_req_addr[IDX_W-1:0];
  assign cpu_tag = cpu_req_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

  coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_idx(cpu_idx), .cpu_st(c_st), .cpu_tag(c_tag), .cpu_data(c_data),
    .snp_idx(snp_idx), .snp_st(s_st), .snp_tag(s_tag), .snp_data(s_data),
    .snp_upd_en(upd_en), .snp_upd_st(upd_st),
    .fill_en(fill_en), .fill_idx(cpu_idx), .fill_tag(fill_tag),
    .fill_data(fill_data), .fill_st(fill_st)
  );

  coh_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) snoop_i (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(snp_tag),
    .line_st(s_st), .line_tag(s_tag), .line_data(s_data),
    .supply(snp_supply), .supply_data(snp_data),
    .upd_en(upd_en), .upd_st(upd_st)
  );

  coh_ctrl_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_idx(cpu_idx), .cpu_tag(cpu_tag), .cpu_wdata(cpu_req_wdata),
    .cpu_req_ready(cpu_req_ready), .cpu_rdata(cpu_rdata),
    .line_st(c_st), .line_tag(c_tag), .line_data(c_data),
    .snp_valid(snp_valid),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_valid(bus_cmd_valid),
    .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_done(bus_done), .bus_rdata(bus_rdata),
    .fill_en(fill_en), .fill_tag(fill_tag), .fill_data(fill_data), .fill_st(fill_st)
  );

  // R8/R1: no data is ever driven without a snoop on the bus
  assert_quiet_supply_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_valid |-> !snp_supply);

endmodule

// File: tb/snoop_wi_cache_tb.sv
`timescale 1ns/100ps
module snoop_wi_cache_tb_top;
  localparam int AW = 12;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic cpu_req_valid, cpu_req_ready, cpu_req_write;
  logic [AW-1:0] cpu_req_addr;
  logic [DW-1:0] cpu_req_wdata, cpu_rdata;
  logic bus_req, bus_gnt, bus_cmd_valid, bus_done;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic snp_valid, snp_supply;
  logic [1:0] snp_cmd;
  logic [AW-1:0] snp_addr;
  logic [DW-1:0] snp_data;

  snoop_wi_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_valid(bus_cmd_valid),
    .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_done(bus_done), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_supply(snp_supply), .snp_data(snp_data)
  );

  int n_chk = 0;
  int n_err = 0;
  bit fin = 0;
  string cur_req = "R2";
  logic [DW-1:0] mem [0:255];
  logic [DW-1:0] exp_q [$];
  int            lg_cmd [$];
  logic [AW-1:0] lg_addr [$];
  logic [DW-1:0] lg_data [$];

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: every completed read pops one expected word
  initial forever begin
    @(negedge clk); #1.5;
    if (rst_n && cpu_req_valid && cpu_req_ready && !cpu_req_write) begin
      if (exp_q.size() == 0) chk(1'b0, cur_req, "unexpected read completion", 64'(cpu_rdata), 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(cpu_rdata === e, cur_req, "read data", 64'(cpu_rdata), 64'(e));
      end
    end
  end

  // bus and memory model
  int pend = 0;
  bit prev_cv = 0;
  logic [AW-1:0] pend_addr;
  initial begin
    bus_gnt = 0; bus_done = 0; bus_rdata = '0; pend_addr = '0;
    forever begin
      @(negedge clk); #1;
      bus_done = 0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          bus_done  = 1;
          bus_rdata = mem[pend_addr[7:0]];
        end
      end
      bus_gnt = rst_n && bus_req;
      #0.5;
      if (rst_n && bus_cmd_valid) begin
        chk(bus_gnt && pend == 0 && !bus_done && !prev_cv, "R11", "command issue rule", 64'(pend), 0);
        lg_cmd.push_back(int'(bus_cmd));
        lg_addr.push_back(bus_addr);
        lg_data.push_back(bus_wdata);
        if (bus_cmd == 2'd3) mem[bus_addr[7:0]] = bus_wdata;
        pend = 2;
        pend_addr = bus_addr;
      end
      prev_cv = bus_cmd_valid;
    end
  end

  task automatic cpu_op(bit wr, logic [AW-1:0] a, logic [DW-1:0] wd,
                        logic [DW-1:0] exp_rd, string req, output int waits);
    @(negedge clk);
    cur_req = req;
    cpu_req_valid = 1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = wd;
    if (!wr) exp_q.push_back(exp_rd);
    waits = 0;
    #2;
    while (!cpu_req_ready) begin
      waits++;
      @(negedge clk); #2;
    end
    @(negedge clk);
    cpu_req_valid = 0;
  endtask

  task automatic snoop(logic [1:0] c, logic [AW-1:0] a, bit exp_sup,
                       logic [DW-1:0] exp_d, string req);
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    #2;
    chk(snp_supply === exp_sup, req, "snoop supply", 64'(snp_supply), 64'(exp_sup));
    if (exp_sup) chk(snp_data === exp_d, req, "snoop data", 64'(snp_data), 64'(exp_d));
    @(negedge clk);
    snp_valid = 0;
  endtask

  task automatic chk_cmd(int idx, int cmd, logic [AW-1:0] a, string req);
    if (lg_cmd.size() <= idx) chk(1'b0, req, "missing bus command", 64'(lg_cmd.size()), 64'(idx + 1));
    else begin
      chk(lg_cmd[idx] == cmd, req, "bus command code", 64'(lg_cmd[idx]), 64'(cmd));
      chk(lg_addr[idx] == a, req, "bus command address", 64'(lg_addr[idx]), 64'(a));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_err++;
      $display("FAIL R13 watchdog expired: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int w, n;
    for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 + i;
    rst_n = 0; cpu_req_valid = 0; cpu_req_write = 0; cpu_req_addr = '0;
    cpu_req_wdata = '0; snp_valid = 0; snp_cmd = '0; snp_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    chk(!bus_req && !bus_cmd_valid && !snp_supply, "R1", "idle outputs after reset",
        64'({bus_req, bus_cmd_valid, snp_supply}), 0);
    snoop(2'd1, 12'h010, 1'b0, '0, "R1");

    // R2 read miss, then R3 hit
    cpu_op(0, 12'h010, '0, 32'hA000_0010, "R2", w);
    chk(w > 0, "R13", "miss stalls", 64'(w), 1);
    chk(lg_cmd.size() == 1, "R2", "one command", 64'(lg_cmd.size()), 1);
    chk_cmd(0, 1, 12'h010, "R2");
    cpu_op(0, 12'h010, '0, 32'hA000_0010, "R3", w);
    chk(w == 0 && lg_cmd.size() == 1, "R3", "shared hit no bus", 64'(w), 0);

    // R4 write to shared posts write miss; R5 exclusive hits
    cpu_op(1, 12'h010, 32'h1111_0001, '0, "R4", w);
    chk_cmd(1, 2, 12'h010, "R4");
    cpu_op(0, 12'h010, '0, 32'h1111_0001, "R4", w);
    chk(w == 0 && lg_cmd.size() == 2, "R5", "exclusive read hit", 64'(lg_cmd.size()), 2);
    cpu_op(1, 12'h010, 32'h2222_0002, '0, "R5", w);
    chk(w == 0 && lg_cmd.size() == 2, "R5", "exclusive write hit", 64'(w), 0);

    // R7 supply and downgrade
    snoop(2'd1, 12'h010, 1'b1, 32'h2222_0002, "R7");
    cpu_op(1, 12'h010, 32'h3333_0003, '0, "R7", w);
    chk_cmd(2, 2, 12'h010, "R7");
    snoop(2'd1, 12'h010, 1'b1, 32'h3333_0003, "R7");
    // R8 shared line not supplied, stays shared
    snoop(2'd1, 12'h010, 1'b0, '0, "R8");
    cpu_op(0, 12'h010, '0, 32'h3333_0003, "R8", w);
    chk(w == 0 && lg_cmd.size() == 3, "R8", "still shared hit", 64'(lg_cmd.size()), 3);

    // R12 mismatching tag, then R6 invalidation
    snoop(2'd2, 12'h018, 1'b0, '0, "R12");
    cpu_op(0, 12'h010, '0, 32'h3333_0003, "R12", w);
    chk(w == 0 && lg_cmd.size() == 3, "R12", "line untouched", 64'(lg_cmd.size()), 3);
    snoop(2'd2, 12'h010, 1'b0, '0, "R6");
    cpu_op(0, 12'h010, '0, 32'hA000_0010, "R6", w);
    chk_cmd(3, 1, 12'h010, "R6");

    // R9 dirty victim written back first; clean victim dropped
    cpu_op(1, 12'h021, 32'h4444_0004, '0, "R9", w);
    chk_cmd(4, 2, 12'h021, "R9");
    cpu_op(0, 12'h029, '0, 32'hA000_0029, "R9", w);
    chk_cmd(5, 3, 12'h021, "R9");
    if (lg_data.size() > 5) chk(lg_data[5] == 32'h4444_0004, "R9", "write-back data", 64'(lg_data[5]), 64'h4444_0004);
    chk_cmd(6, 1, 12'h029, "R9");
    n = lg_cmd.size();
    cpu_op(0, 12'h031, '0, 32'hA000_0031, "R9", w);
    chk(lg_cmd.size() == n + 1, "R9", "clean victim no write-back", 64'(lg_cmd.size()), 64'(n + 1));
    chk_cmd(n, 1, 12'h031, "R9");

    // R10 snoop in the same cycle as a hit
    @(negedge clk);
    cur_req = "R10";
    cpu_req_valid = 1; cpu_req_write = 0; cpu_req_addr = 12'h031;
    exp_q.push_back(32'hA000_0031);
    snp_valid = 1; snp_cmd = 2'd1; snp_addr = 12'h044;
    #2; chk(!cpu_req_ready, "R10", "held off by snoop", 64'(cpu_req_ready), 0);
    @(negedge clk); snp_valid = 0;
    #2; chk(cpu_req_ready, "R10", "served after snoop", 64'(cpu_req_ready), 1);
    @(negedge clk); cpu_req_valid = 0;

    cpu_op(0, 12'h021, '0, 32'h4444_0004, "R9", w);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "scoreboard drained", 64'(exp_q.size()), 0);
    chk(!bus_req, "R13", "bus released", 64'(bus_req), 0);
    fin = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule